// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Engine with Status Polling

This block models the write path of a byte-wide nonvolatile memory that a host drives like a synchronous SRAM. A host write strobe carries an address and a data byte. The first write opens a page load. Later writes to the same page go into a page buffer, and each one restarts a load window. When the window expires with no new write, the block closes the load on its own and starts a timed programming phase. In that phase only the buffered bytes are copied into an internal storage array. The block needs no further host action once programming has begun.

The address splits into a byte offset (the low `PAGE_BITS` bits) and a page number (the remaining upper bits). While programming runs, the `busy` output is high and reads return a status byte instead of array data. In the status byte, bit 7 is the complement of bit 7 of the last byte written and bit 6 alternates on each read. A host can therefore detect completion by polling either bit. The load window and the programming time are both given in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is asserted, `busy` is 0 and `rdata` is 0.
- R2: A write while idle opens a page load and is accepted. `busy` stays 0 during the load, and reads during the load return the array's current (not yet programmed) contents.
- R3: Each accepted write restarts a window of `LOAD_WIN_CYC` cycles. If the last accepted write lands on clock edge k, `busy` rises on edge k+`LOAD_WIN_CYC`. A same-page write arriving on that same edge is still accepted.
- R4: After it rises, `busy` stays high for exactly `PROG_CYC` cycles and then returns to 0 without any host action.
- R5: Programming writes only the offsets loaded in this page load, each with the last value written to it. Bytes may be loaded in any order. All other bytes of the page keep their previous contents.
- R6: During a load, a write whose page number (address bits above the low `PAGE_BITS`) differs from the open page is dropped. It changes no memory and does not restart the window.
- R7: Writes that arrive while `busy` is high are ignored and change no memory.
- R8: A read while `busy` is high returns a byte whose bit 7 is the complement of bit 7 of the last accepted byte of the load.
- R9: In reads while `busy` is high, bit 6 is 0 on the first status read of each programming phase and inverts on every further status read.
- R10: With `ECHO_LOW`=1 (the default), status bits 5..0 equal bits 5..0 of the last accepted byte. With `ECHO_LOW`=0 they are 0.
- R11: `rdata` updates on the clock edge that samples `rd_en` and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address: page number in the upper bits, offset in the low PAGE_BITS bits |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data, or the status byte while busy |
| busy | output | 1 | High while the programming phase runs |

## Verification
A full sequential fill of one page checks the plain write path and the exact window and programming lengths. A second load to the same page writes offsets out of order and overwrites one offset. Its readback separates "only touched bytes programmed" from "whole page rewritten", and "last value kept" from "first value kept". An off-page write placed a few cycles into a window shows whether a dropped write still restarts the timer. A write attempted during programming shows whether busy writes are blocked. Status reads after loads ending in bytes with bit 7 set and with bit 7 clear separate a true complement from a fixed value. Consecutive status reads show that bit 6 alternates.

// File: rtl/epw_pkg.sv
package epw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } epw_state_e;
endpackage

// File: rtl/epw_cycle_timer.sv
module epw_cycle_timer #(
   parameter int MAX_CYC = 16,
   localparam int TW = $clog2(MAX_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          en,
   output logic          zero
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (en && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R3 / R4: a nonzero reload cannot expire on the following cycle
   assert_reload_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/epw_page_buf.sv
module epw_page_buf #(
   parameter int PAGE_BITS = 7,
   parameter int DATA_W    = 8,
   localparam int PAGE     = 1 << PAGE_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic [PAGE_BITS-1:0] widx,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [PAGE_BITS-1:0] ridx,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rmark
);
   logic [PAGE-1:0]   mark_q;
   logic [DATA_W-1:0] byte_q [PAGE];

   for (genvar i = 0; i < PAGE; i++) begin : g_slot
      logic hit;
      assign hit = wr && (widx == PAGE_BITS'(i));
      always_ff @(posedge clk) begin
         if (!rst_n)   mark_q[i] <= 1'b0;
         else if (hit) mark_q[i] <= 1'b1;
         else if (clr) mark_q[i] <= 1'b0;
      end
      always_ff @(posedge clk) begin
         if (hit) byte_q[i] <= wdata;
      end
   end

   assign rdata = byte_q[ridx];
   assign rmark = mark_q[ridx];

   // R5: a loaded offset is marked for programming
   assert_slot_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> mark_q[$past(widx)]);
endmodule

// File: rtl/epw_status.sv
module epw_status #(
   parameter int DATA_W   = 8,
   parameter bit ECHO_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              poll,
   input  logic [DATA_W-1:0] last_byte,
   output logic [DATA_W-1:0] status
);
   logic tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       tog_q <= 1'b0;
      else if (restart) tog_q <= 1'b0;
      else if (poll)    tog_q <= ~tog_q;
   end

   if (ECHO_LOW) begin : g_echo
      assign status = {~last_byte[7], tog_q, last_byte[5:0]};
   end else begin : g_quiet
      assign status = {~last_byte[7], tog_q, 6'b0};
   end

   // R9: every status read flips the toggle bit
   assert_toggle_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (poll && !restart) |=> tog_q != $past(tog_q));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
   parameter int ADDR_W       = 10,
   parameter int PAGE_BITS    = 7,
   parameter int LOAD_WIN_CYC = 15000,
   parameter int PROG_CYC     = 1000000,
   parameter bit ECHO_LOW     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              busy
);
   import epw_pkg::*;

   localparam int PAGE  = 1 << PAGE_BITS;
   localparam int PG_W  = ADDR_W - PAGE_BITS;
   localparam int DEPTH = 1 << ADDR_W;
   localparam int IW    = PAGE_BITS + 1;
   localparam int LTW   = $clog2(LOAD_WIN_CYC + 1);
   localparam int PTW   = $clog2(PROG_CYC + 1);

   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("PAGE_BITS must lie in 1..ADDR_W-1");
   end
   if (LOAD_WIN_CYC < 1) begin : g_bad_win
      $error("LOAD_WIN_CYC must be at least 1");
   end
   if (PROG_CYC < PAGE) begin : g_bad_prog
      $error("PROG_CYC must cover one commit cycle per page byte");
   end

   epw_state_e            state_q;
   logic [PG_W-1:0]       page_q;
   logic [7:0]            last_q;
   logic [IW-1:0]         cidx_q;
   logic [7:0]            mem [DEPTH];

   logic [PG_W-1:0]       addr_pg;
   logic [PAGE_BITS-1:0]  addr_off;
   logic                  acc_wr, open_wr, load_zero, prog_zero;
   logic                  enter_prog, leave_prog, commit_we;
   logic [7:0]            buf_byte, status_byte;
   logic                  buf_mark;

   assign addr_pg  = addr[ADDR_W-1:PAGE_BITS];
   assign addr_off = addr[PAGE_BITS-1:0];
   assign open_wr  = wr_en && (state_q == ST_IDLE);
   assign acc_wr   = open_wr ||
                     (wr_en && state_q == ST_LOAD && addr_pg == page_q);
   assign enter_prog = (state_q == ST_LOAD) && !acc_wr && load_zero;
   assign leave_prog = (state_q == ST_PROG) && prog_zero;
   assign busy       = (state_q == ST_PROG);

   epw_cycle_timer #(.MAX_CYC(LOAD_WIN_CYC)) u_win (
      .clk(clk), .rst_n(rst_n), .load(acc_wr),
      .load_val(LTW'(LOAD_WIN_CYC - 1)),
      .en(state_q == ST_LOAD), .zero(load_zero));

   epw_cycle_timer #(.MAX_CYC(PROG_CYC)) u_prog (
      .clk(clk), .rst_n(rst_n), .load(enter_prog),
      .load_val(PTW'(PROG_CYC - 1)),
      .en(state_q == ST_PROG), .zero(prog_zero));

   epw_page_buf #(.PAGE_BITS(PAGE_BITS), .DATA_W(8)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(open_wr), .wr(acc_wr),
      .widx(addr_off), .wdata(wdata),
      .ridx(cidx_q[PAGE_BITS-1:0]), .rdata(buf_byte), .rmark(buf_mark));

   epw_status #(.DATA_W(8), .ECHO_LOW(ECHO_LOW)) u_stat (
      .clk(clk), .rst_n(rst_n), .restart(enter_prog),
      .poll(rd_en && busy), .last_byte(last_q), .status(status_byte));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         page_q  <= '0;
         last_q  <= '0;
      end else begin
         if (acc_wr) last_q <= wdata;
         if (open_wr) page_q <= addr_pg;
         unique case (state_q)
            ST_IDLE: if (open_wr) state_q <= ST_LOAD;
            ST_LOAD: if (enter_prog) state_q <= ST_PROG;
            ST_PROG: if (leave_prog) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // one page offset committed per programming cycle
   always_ff @(posedge clk) begin
      if (!rst_n)                          cidx_q <= '0;
      else if (enter_prog)                 cidx_q <= '0;
      else if (busy && cidx_q < IW'(PAGE)) cidx_q <= cidx_q + 1'b1;
   end

   assign commit_we = busy && (cidx_q < IW'(PAGE)) && buf_mark;

   always_ff @(posedge clk) begin
      if (commit_we) mem[{page_q, cidx_q[PAGE_BITS-1:0]}] <= buf_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= busy ? status_byte : mem[addr];
   end

   // R7: host writes during programming leave the load state untouched
   assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> ($stable(page_q) && $stable(last_q)));

   // R8: status reads present the complement of the last byte's top bit
   assert_poll_bit7_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> rdata[7] != $past(last_q[7]));

   // R6: a write to a foreign page during a load keeps the open page
   assert_offpage_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD && wr_en && addr_pg != page_q) |=> $stable(page_q));

   // R11: without a read strobe the output register holds
   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
   localparam int AW = 10;
   localparam int PB = 7;
   localparam int LW = 20;
   localparam int PC = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          busy;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct { logic [7:0] exp; string tag; } item_t;
   item_t      sb_q[$];
   logic [7:0] refm [1 << AW];
   logic [7:0] pend [int];

   always #5 clk = ~clk;

   eeprom_page_writer #(.ADDR_W(AW), .PAGE_BITS(PB), .LOAD_WIN_CYC(LW),
                        .PROG_CYC(PC), .ECHO_LOW(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   // monitor: pops one expected item per sampled read
   always @(posedge clk) begin : mon
      item_t it;
      if (rd_en) begin
         #2;
         if (sb_q.size() == 0) check(1'b0, "R11 unexpected read", rdata, 0);
         else begin
            it = sb_q.pop_front();
            check(rdata === it.exp, it.tag, rdata, it.exp);
         end
      end
   end

   task automatic do_wr(input int a, input logic [7:0] d);
      addr = AW'(a); wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic page_wr(input int a, input logic [7:0] d);
      do_wr(a, d);
      pend[a] = d;
   endtask

   task automatic do_rd(input int a, input logic [7:0] exp, input string tag);
      item_t it;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      addr = AW'(a); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_rise(output int n);
      n = 0;
      while (!busy && n < 100000) begin @(negedge clk); n++; end
   endtask

   task automatic wait_fall(output int n);
      n = 0;
      while (busy && n < 100000) begin @(negedge clk); n++; end
   endtask

   task automatic commit();
      foreach (pend[k]) refm[k] = pend[k];
      pend.delete();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin : main
      int n;
      int m;
      foreach (refm[k]) refm[k] = 8'h00;
      repeat (3) @(negedge clk);
      check(rdata == 8'h00, "R1 rdata in reset", rdata, 0);
      check(busy == 1'b0, "R1 busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // full sequential page fill, page 1
      for (int i = 0; i < 128; i++) page_wr(128 + i, 8'((i * 3 + 1) & 255));
      check(busy == 1'b0, "R2 busy low during load", busy, 0);
      wait_rise(n);
      check(n == LW, "R3 window length", n, LW);
      wait_fall(m);
      check(m == PC, "R4 programming length", m, PC);
      commit();

      // one byte on page 3
      page_wr(3 * 128 + 7, 8'h11);
      wait_rise(n);
      check(n == LW, "R3 single-byte window", n, LW);
      wait_fall(m);
      commit();

      // out-of-order partial load with overwrite, page 1
      page_wr(128 + 5, 8'hA5);
      do_rd(128 + 5, refm[133], "R2 read during load is old data");
      page_wr(128 + 2, 8'h3C);
      page_wr(128 + 5, 8'h5A);
      page_wr(128 + 100, 8'hC3);
      repeat (4) @(negedge clk);
      do_wr(3 * 128 + 7, 8'hEE);           // foreign page, dropped
      wait_rise(n);
      check(n == LW - 5, "R6 dropped write keeps window", n, LW - 5);
      do_rd(0, 8'h03, "R8 status bit7 inverted");
      do_rd(0, 8'h43, "R9 status bit6 toggles");
      do_wr(128 + 0, 8'h77);               // during busy, ignored
      do_rd(5, 8'h03, "R10 status low bits echo");
      wait_fall(m);
      check(m + 4 == PC, "R4 self-timed with host traffic", m + 4, PC);
      commit();
      do_rd(128 + 5, refm[133], "R5 overwritten byte keeps last value");
      do_rd(128 + 2, refm[130], "R5 loaded byte");
      do_rd(128 + 100, refm[228], "R5 loaded byte high offset");
      do_rd(128 + 0, refm[128], "R7 busy write ignored");
      do_rd(128 + 1, refm[129], "R5 untouched byte kept");
      do_rd(128 + 127, refm[255], "R5 untouched last byte kept");
      do_rd(3 * 128 + 7, refm[391], "R6 foreign page unchanged");

      // last byte with bit 7 clear, page 0
      page_wr(9, 8'h2B);
      wait_rise(n);
      do_rd(9, 8'hAB, "R8 status bit7 set when data bit7 clear");
      do_rd(9, 8'hEB, "R9 second status read bit6 high");
      wait_fall(m);
      commit();
      do_rd(9, refm[9], "R5 programmed after status reads");
      repeat (5) @(negedge clk);
      check(rdata == refm[9], "R11 rdata holds without read", rdata, refm[9]);
      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R11 all reads returned", sb_q.size(), 0);
      report();
   end
endmodule